// File: doc/BRIEF.md
# Power-Up Strap Latch and Run Sequencer

This block sequences the start-up and the power-down of a multi-output clock generator. After a power-on reset it treats a shared pin as an undriven input. It waits for a settling interval and captures that pin together with two dedicated select pins as a three-bit strap. From then on it drives the shared pin as a clock output. The captured strap is decoded into a flat operating mode: all outputs floated, test, or one of three host-clock frequencies. The outputs stay gated off until a stabilisation interval has also elapsed.

An active-low power-down input is synchronised inside the block. A stop takes effect only in a cycle that the clock-phase input marks as low, so no generated clock is cut short. While powered down, the serial control interface is disabled. Releasing power-down restarts the stabilisation interval. The strap is not captured again.

Top module: `pwrup_strap_ctrl`

## Requirements
- R1: While reset is asserted, and until the strap is captured, the shared pin is undriven (`pin_drive`=0), `run_outputs`=0, `serial_en`=0, the strap reads as 000 (`tristate_mode`=1, `test_mode`=0, `host_sel`=3).
- R2: After reset is released, `pin_drive` rises exactly after SETTLE_CYCLES rising clock edges and never falls again until the next reset.
- R3: The strap is captured as {`strap_pin_in`, `sel_pins[1]`, `sel_pins[0]`} on the edge at which `pin_drive` rises. Later changes on those inputs have no effect on the decoded mode.
- R4: The strap {s2,s1,s0} decodes as follows:
  - s1=0, s0=1 gives `test_mode`=1 and `host_sel`=3.
  - s1=0, s0=0 gives `tristate_mode`=1 and `host_sel`=3.
  - s1=1, s2=1 gives `host_sel`=2 (133 MHz).
  - s1=1, s2=0 gives `host_sel`=s0, where 0 is 66 MHz and 1 is 100 MHz.
  - Both flags are 0 whenever s1=1.
- R5: After the strap is captured, `serial_en` is 1. `run_outputs` rises no earlier than STAB_CYCLES edges later, at the first such edge where `clk_low_phase` is 1.
- R6: `pd_n` passes through a two-stage synchroniser. A low level that reaches its output stops the outputs (`run_outputs` to 0) and disables the serial interface (`serial_en` to 0) on an edge where `clk_low_phase` is 1. While `clk_low_phase` is 0, the outputs keep running.
- R7: When the synchronised `pd_n` returns high, `serial_en` returns to 1 and the stabilisation interval of R5 starts again from zero. The strap is not re-captured.
- R8: A synchronised power-down during the stabilisation interval disables the serial interface without waiting for a low phase.
- R9: `run_outputs` changes value only on edges where `clk_low_phase` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| strap_pin_in | input | 1 | Value seen on the shared strap/clock pin |
| sel_pins | input | 2 | Dedicated select pins {s1,s0} |
| pd_n | input | 1 | Active-low power-down request, asynchronous |
| clk_low_phase | input | 1 | High when the generated clocks are in their low phase |
| pin_drive | output | 1 | 1 when the shared pin is driven as a clock output |
| tristate_mode | output | 1 | Decoded mode: all outputs floated |
| test_mode | output | 1 | Decoded mode: test clocking |
| host_sel | output | 2 | Host frequency: 0=66, 1=100, 2=133, 3=none |
| serial_en | output | 1 | Serial control interface enable |
| run_outputs | output | 1 | Clock outputs allowed to toggle |

## Verification
The bench walks all eight strap values. A decoder with the test/tristate priority swapped, or with s2 weighed wrongly, shows a wrong flag or frequency. It pins the exact edge where the shared pin turns around and wiggles the strap inputs afterwards. A block that resamples the strap, or that latches one edge early or late, changes mode or shows the wrong pin direction. It holds the phase input low across a stop request and across the end of stabilisation, which catches a block that would clip a clock. It also checks a power-down cycle for the two-stage synchroniser delay, for the restarted stabilisation count, and for a strap that stays as captured.

// File: rtl/pwrup_strap_ctrl.sv
module pwrup_strap_ctrl #(
  parameter int SETTLE_CYCLES = 64,
  parameter int STAB_CYCLES   = 42955
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_pin_in,
  input  logic [1:0] sel_pins,
  input  logic       pd_n,
  input  logic       clk_low_phase,
  output logic       pin_drive,
  output logic       tristate_mode,
  output logic       test_mode,
  output logic [1:0] host_sel,
  output logic       serial_en,
  output logic       run_outputs
);
  localparam int MAXC = (SETTLE_CYCLES > STAB_CYCLES) ? SETTLE_CYCLES : STAB_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0] STAB_LAST   = CW'(STAB_CYCLES - 1);

  typedef enum logic [1:0] {S_SETTLE, S_STAB, S_RUN, S_DOWN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    strap;
  logic [1:0]    pd_s;
  logic          pd_low;

  assign pd_low = ~pd_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_s <= 2'b11;
    else        pd_s <= {pd_s[0], pd_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_SETTLE;
      cnt   <= '0;
      strap <= 3'b000;
    end else begin
      case (st)
        S_SETTLE:
          if (cnt == SETTLE_LAST) begin
            strap <= {strap_pin_in, sel_pins};
            cnt   <= '0;
            st    <= S_STAB;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_STAB:
          if (pd_low) begin
            st <= S_DOWN;
          end else if (cnt == STAB_LAST) begin
            if (clk_low_phase) st <= S_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_RUN:
          if (pd_low && clk_low_phase) st <= S_DOWN;
        S_DOWN:
          if (!pd_low) begin
            cnt <= '0;
            st  <= S_STAB;
          end
        default: st <= S_SETTLE;
      endcase
    end
  end

  assign pin_drive     = (st != S_SETTLE);
  assign serial_en     = (st == S_STAB) || (st == S_RUN);
  assign run_outputs   = (st == S_RUN);
  assign test_mode     = ~strap[1] &  strap[0];
  assign tristate_mode = ~strap[1] & ~strap[0];
  assign host_sel      = !strap[1] ? 2'd3 : (strap[2] ? 2'd2 : {1'b0, strap[0]});
endmodule

module pwrup_strap_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_low_phase,
  input logic       pin_drive,
  input logic       tristate_mode,
  input logic       test_mode,
  input logic [1:0] host_sel,
  input logic       serial_en,
  input logic       run_outputs
);
  // R2
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_drive) |-> pin_drive);
  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_drive && $past(pin_drive)) |-> ($stable(host_sel) && $stable(test_mode) && $stable(tristate_mode)));
  // R9
  run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_outputs) |-> $past(clk_low_phase));
  // R9
  run_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_outputs) |-> $past(clk_low_phase));
  // R6
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_outputs |-> (serial_en && pin_drive));
endmodule

bind pwrup_strap_ctrl pwrup_strap_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_low_phase(clk_low_phase), .pin_drive(pin_drive),
  .tristate_mode(tristate_mode), .test_mode(test_mode), .host_sel(host_sel),
  .serial_en(serial_en), .run_outputs(run_outputs)
);

// File: tb/pwrup_strap_ctrl_test.sv
module pwrup_strap_ctrl_test;
  localparam int PERIOD = 10;
  localparam int SETTLE = 8;
  localparam int STAB   = 12;
  // {strap s2 s1 s0, tristate, test, host_sel}
  localparam logic [6:0] VEC [8] = '{
    7'b000_1_0_11, 7'b001_0_1_11, 7'b010_0_0_00, 7'b011_0_0_01,
    7'b100_1_0_11, 7'b101_0_1_11, 7'b110_0_0_10, 7'b111_0_0_10
  };

  logic clk = 0, rst_n = 0, strap_pin_in = 0, pd_n = 1, clk_low_phase = 1;
  logic [1:0] sel_pins = 0;
  logic pin_drive, tristate_mode, test_mode, serial_en, run_outputs;
  logic [1:0] host_sel;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pwrup_strap_ctrl #(.SETTLE_CYCLES(SETTLE), .STAB_CYCLES(STAB)) uut (
    .clk(clk), .rst_n(rst_n), .strap_pin_in(strap_pin_in), .sel_pins(sel_pins),
    .pd_n(pd_n), .clk_low_phase(clk_low_phase), .pin_drive(pin_drive),
    .tristate_mode(tristate_mode), .test_mode(test_mode), .host_sel(host_sel),
    .serial_en(serial_en), .run_outputs(run_outputs));

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(logic [2:0] s);
    rst_n = 0; pd_n = 1; clk_low_phase = 1;
    strap_pin_in = s[2]; sel_pins = s[1:0];
    tick(2);
    rst_n = 1;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(1);
    chk("R1 pin_drive", pin_drive, 0);
    chk("R1 run", run_outputs, 0);
    chk("R1 serial", serial_en, 0);
    chk("R1 tristate", tristate_mode, 1);
    chk("R1 host", host_sel, 3);

    // R4 decode table walk
    for (int i = 0; i < 8; i++) begin
      start(VEC[i][6:4]);
      tick(SETTLE + STAB);
      chk("R4 run", run_outputs, 1);
      chk("R4 tristate", tristate_mode, VEC[i][3]);
      chk("R4 test", test_mode, VEC[i][2]);
      chk("R4 host", host_sel, VEC[i][1:0]);
    end

    // R2 R3 exact turnaround and strap capture
    start(3'b011);
    tick(SETTLE - 1);
    chk("R2 pin before", pin_drive, 0);
    chk("R1 host before latch", host_sel, 3);
    tick(1);
    chk("R2 pin after", pin_drive, 1);
    chk("R5 serial after latch", serial_en, 1);
    strap_pin_in = 1; sel_pins = 2'b00;
    tick(3);
    chk("R3 host held", host_sel, 1);
    chk("R3 tristate held", tristate_mode, 0);

    // R5 stabilisation waits for low phase
    tick(STAB - 4);
    chk("R5 run before stab end", run_outputs, 0);
    clk_low_phase = 0;
    tick(1);
    chk("R5 stab end high phase", run_outputs, 0);
    tick(3);
    chk("R5 still waiting phase", run_outputs, 0);
    clk_low_phase = 1;
    tick(1);
    chk("R5 run on low phase", run_outputs, 1);

    // R6 synchronised stop, only on low phase
    pd_n = 0;
    tick(2);
    chk("R6 sync latency", run_outputs, 1);
    clk_low_phase = 0;
    tick(3);
    chk("R6 held in high phase", run_outputs, 1);
    chk("R6 serial held", serial_en, 1);
    clk_low_phase = 1;
    tick(1);
    chk("R6 stopped", run_outputs, 0);
    chk("R6 serial off", serial_en, 0);
    chk("R6 pin still driven", pin_drive, 1);

    // R7 release restarts stabilisation, no re-capture
    strap_pin_in = 1; sel_pins = 2'b11;
    pd_n = 1;
    tick(2);
    chk("R7 serial still off", serial_en, 0);
    tick(1);
    chk("R7 serial back", serial_en, 1);
    tick(STAB - 1);
    chk("R7 run before restab", run_outputs, 0);
    tick(1);
    chk("R7 run after restab", run_outputs, 1);
    chk("R7 host not resampled", host_sel, 1);

    // R8 power-down during stabilisation, no phase wait
    start(3'b110);
    tick(SETTLE + 2);
    clk_low_phase = 0;
    pd_n = 0;
    tick(3);
    chk("R8 serial off in stab", serial_en, 0);
    chk("R8 run off", run_outputs, 0);
    chk("R8 host kept", host_sel, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule